// File: doc/BRIEF.md
# SDRAM command-mode sequencer

This unit lets a host bring up and look after SDRAM devices on one or two chip selects. The host writes a 32-bit command word over a simple register bus. The word selects what to do and which chip selects receive it. It can also carry a repeat count for auto-refresh and a payload for the device mode register. The unit then drives the SDRAM control pins for that command. It holds off further commands for the delays programmed in a timing register, and it shows a busy flag in a status word that the host polls between steps.

A typical bring-up runs in this order: enable the clock, precharge all banks, send a burst of auto-refreshes, load the mode register, and return to normal. Once the devices are running, a refresh interval register arms a periodic timer. Each time the timer runs out, the unit sends one auto-refresh to every chip select whose clock has been enabled. Self-refresh and power-down entry drop CKE. A later normal-mode command brings the devices back, and the unit waits out the exit time.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The command word selects an action with bits [2:0]: 0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode, 5 self-refresh, 6 power-down. Code 7 is dropped: it causes no pin activity, no busy period, and leaves the stored command word and CKE as they were.
- R2: Command bit 4 selects chip select 0 (sd_cs_n[0] low) and bit 3 selects chip select 1 (sd_cs_n[1] low). When both are set, both chip selects are driven low in the same cycle.
- R3: Precharge all drives RAS_n=0, CAS_n=1, WE_n=0 with address bit 10 high for one cycle. It then waits tRP+1 cycles, so busy lasts tRP+2 cycles.
- R4: Auto-refresh with count field bits [8:5] = N sends N+1 refresh commands (RAS_n=0, CAS_n=0, WE_n=1) spaced tRC+2 cycles apart. Chip selects stay high between commands, and busy lasts (N+1)·(tRC+2) cycles.
- R5: Load mode drives RAS_n, CAS_n and WE_n low, with the address bus equal to command bits [21:9] and bank address 0. Busy lasts tMRD+2 cycles.
- R6: Clock enable raises CKE and sends one NOP to the selected chip selects (CS_n low, RAS_n, CAS_n and WE_n high). Busy lasts one cycle.
- R7: Self-refresh sends a refresh command with CKE already low, and busy lasts tRAS+2 cycles. Power-down sends a NOP with CKE low, and busy lasts one cycle. A normal command after either of these raises CKE, sends a NOP, and holds busy for tXSR+2 cycles. A normal command at any other time sends nothing and is busy for one cycle.
- R8: Status bit 5 is busy. It reads 1 starting in the cycle after a command is accepted, and it clears when the final wait has elapsed. The chip selects stay high whenever the unit is not busy.
- R9: A command write while busy is dropped and sets the sticky status bit 0. Writing status with bit 0 set clears that bit.
- R10: The timing word holds 4-bit fields at shifts 0, 4, 8, 12, 16, 20 and 24, for tMRD, tXSR, tRAS, tRC, tWR, tRP and tRCD. A field value V means V+1 cycles.
- R11: The refresh word's interval C sits at bits [13:1]. When C is nonzero and CKE is high, one refresh goes to every clock-enabled chip select every C+1 cycles. The first one appears C+1 cycles after the write. Writing C=0 stops the timer.
- R12: If the refresh interval expires while the unit is busy, the refresh is held. It is sent in the cycle after the first idle cycle.
- R13: Bus reads at offset 0 return the command word, offset 1 the timing word, offset 2 the refresh word, and offset 3 the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 command, 1 timing, 2 refresh, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address bus |
| sd_ba | output | 2 | SDRAM bank address |

## Verification
The bench uses the default parameters: a 13-bit address bus, 4-bit timing fields, a 4-bit refresh repeat count and a 13-bit refresh interval. The timing word is programmed with small values (tMRD 1, tXSR 5, tRAS 4, tRC 2, tRP 3), so every wait lasts only a few cycles and exact issue cycles can be predicted. These settings allow a full eight-refresh burst to be checked command by command. Refresh intervals of 30 and 40 cycles fit several timer periods into a short run. One of them lands an expiry in the middle of a host burst, which exercises the held refresh.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ADDR_W = 13,
  parameter int TF_W   = 4,
  parameter int RPT_W  = 4,
  parameter int REF_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [1:0]        sd_ba
);
  localparam int PAY_LO = 5 + RPT_W;
  localparam int PAY_W  = 13;
  localparam int PAY_HI = PAY_LO + PAY_W - 1;
  localparam logic [1:0] A_CMD = 2'd0, A_TIM = 2'd1, A_REF = 2'd2, A_STS = 2'd3;
  localparam int F_MRD = 0, F_XSR = 1, F_RAS = 2, F_RC = 3, F_RP = 5;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t              st;
  logic [31:0]      cmd_q, tim_q;
  logic [REF_W-1:0] rtr_q, tmr_q;
  logic [2:0]       mode_q;
  logic [1:0]       tgt_q, bank_en;
  logic [RPT_W-1:0] reps_q;
  logic [TF_W-1:0]  cnt_q, wait_v;
  logic [PAY_W-1:0] pay_q;
  logic             cke_q, lp_q, wake_q, err_q, pend_q, need_wait;

  wire busy    = (st != S_IDLE);
  wire cmd_wr  = bus_wr && (bus_addr == A_CMD);
  wire ref_wr  = bus_wr && (bus_addr == A_REF);
  wire host_go = cmd_wr && !busy && (bus_wdata[2:0] != 3'd7);
  wire expire  = (rtr_q != '0) && (tmr_q == '0) && !ref_wr;
  wire ref_go  = !busy && !host_go && (pend_q || expire) && cke_q && (bank_en != 2'b00);

  always_comb begin
    need_wait = 1'b1;
    wait_v    = '0;
    case (mode_q)
      3'd0: begin need_wait = wake_q; wait_v = tim_q[F_XSR*TF_W +: TF_W]; end
      3'd2: wait_v = tim_q[F_RP*TF_W +: TF_W];
      3'd3: wait_v = tim_q[F_RC*TF_W +: TF_W];
      3'd4: wait_v = tim_q[F_MRD*TF_W +: TF_W];
      3'd5: wait_v = tim_q[F_RAS*TF_W +: TF_W];
      default: need_wait = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      tim_q <= '0;
      rtr_q <= '0;
      err_q <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CMD: if (busy) err_q <= 1'b1; else if (host_go) cmd_q <= bus_wdata;
        A_TIM: tim_q <= bus_wdata;
        A_REF: rtr_q <= bus_wdata[REF_W:1];
        default: if (bus_wdata[0]) err_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ref_wr) tmr_q <= bus_wdata[REF_W:1];
      else if (rtr_q != '0) tmr_q <= (tmr_q == '0) ? rtr_q : tmr_q - 1'b1;
      if (ref_go) pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_q  <= '0;
      tgt_q   <= '0;
      reps_q  <= '0;
      cnt_q   <= '0;
      pay_q   <= '0;
      cke_q   <= 1'b0;
      lp_q    <= 1'b0;
      wake_q  <= 1'b0;
      bank_en <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (host_go) begin
            mode_q <= bus_wdata[2:0];
            tgt_q  <= {bus_wdata[3], bus_wdata[4]};
            reps_q <= bus_wdata[5 +: RPT_W];
            pay_q  <= bus_wdata[PAY_HI:PAY_LO];
            wake_q <= (bus_wdata[2:0] == 3'd0) && lp_q;
            case (bus_wdata[2:0])
              3'd0: begin
                if (lp_q) cke_q <= 1'b1;
                lp_q <= 1'b0;
              end
              3'd1: begin
                cke_q   <= 1'b1;
                lp_q    <= 1'b0;
                bank_en <= bank_en | {bus_wdata[3], bus_wdata[4]};
              end
              3'd5, 3'd6: begin
                cke_q <= 1'b0;
                lp_q  <= 1'b1;
              end
              default: ;
            endcase
            st <= S_ISSUE;
          end else if (ref_go) begin
            mode_q <= 3'd3;
            tgt_q  <= bank_en;
            reps_q <= '0;
            wake_q <= 1'b0;
            st     <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (need_wait) begin
            cnt_q <= wait_v;
            st    <= S_WAIT;
          end else begin
            st <= S_IDLE;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            if (reps_q != '0) begin
              reps_q <= reps_q - 1'b1;
              st     <= S_ISSUE;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  wire sel    = (st == S_ISSUE) && !((mode_q == 3'd0) && !wake_q);
  wire is_pre = (mode_q == 3'd2);
  wire is_ref = (mode_q == 3'd3) || (mode_q == 3'd5);
  wire is_lmr = (mode_q == 3'd4);

  assign sd_cke   = cke_q;
  assign sd_cs_n  = sel ? ~tgt_q : 2'b11;
  assign sd_ras_n = !(sel && (is_pre || is_ref || is_lmr));
  assign sd_cas_n = !(sel && (is_ref || is_lmr));
  assign sd_we_n  = !(sel && (is_pre || is_lmr));
  assign sd_ba    = 2'b00;

  always_comb begin
    sd_addr = '0;
    if (sel && is_lmr) sd_addr = ADDR_W'(pay_q);
    else if (sel && is_pre) sd_addr[10] = 1'b1;
  end

  always_comb begin
    case (bus_addr)
      A_CMD:   bus_rdata = cmd_q;
      A_TIM:   bus_rdata = tim_q;
      A_REF:   bus_rdata = 32'({rtr_q, 1'b0});
      default: bus_rdata = {26'b0, busy, 4'b0, err_q};
    endcase
  end

  AST_RESV_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && bus_wdata[2:0] == 3'd7) |=> ($stable(cmd_q) && $stable(sd_cke))); // R1
  AST_PRE_A10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]); // R3
  AST_WAIT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (sd_cs_n == 2'b11)); // R4
  AST_SR_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n && !sd_cas_n && sd_we_n && !sd_cke) |=> !sd_cke); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sd_cs_n == 2'b11)); // R8
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    host_go |=> bus_wr || bus_addr != A_STS || bus_rdata[5]); // R8
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (err_q && $stable(cmd_q))); // R9
endmodule

// File: tb/sim_sdram_cmd_seq.sv
`timescale 1ns/1ps
module sim_sdram_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_cs_n, sd_ba;
  logic [12:0] sd_addr;

  sdram_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [52:0] exp_q[$];

  localparam int T_MRD = 1, T_XSR = 5, T_RAS = 4, T_RC = 2, T_RP = 3;
  bit m_lp = 1'b0;

  function automatic logic [52:0] mk(int t, logic [1:0] cs, logic r, logic c, logic w,
                                     logic k, logic [1:0] ba, logic [12:0] a);
    logic [31:0] tt;
    tt = t;
    return {tt, cs, r, c, w, k, ba, a};
  endfunction

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp, string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [52:0] got, e;
    if (rst_n && sd_cs_n != 2'b11 && !done) begin
      got = mk(cyc, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_ba, sd_addr);
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected command: actual %h expected none", cur_req, got);
      end else begin
        e = exp_q.pop_front();
        if (got !== e) begin
          fails++;
          $display("FAIL %s command: actual %h expected %h", cur_req, got, e);
        end
      end
    end
  end

  task automatic send_cmd(string r, logic [2:0] m, logic b1, logic b2, logic [3:0] n,
                          logic [12:0] pay);
    int k, d;
    logic [1:0] cs;
    @(negedge clk);
    k = cyc + 1;
    cs = {~b2, ~b1};
    d = 1;
    case (m)
      3'd0: if (m_lp) begin
        exp_q.push_back(mk(k, cs, 1, 1, 1, 1, 2'b00, 13'h0));
        d = 2 + T_XSR;
        m_lp = 1'b0;
      end
      3'd1: begin exp_q.push_back(mk(k, cs, 1, 1, 1, 1, 2'b00, 13'h0)); m_lp = 1'b0; end
      3'd2: begin exp_q.push_back(mk(k, cs, 0, 1, 0, 1, 2'b00, 13'h400)); d = 2 + T_RP; end
      3'd3: begin
        for (int j = 0; j <= int'(n); j++)
          exp_q.push_back(mk(k + j * (T_RC + 2), cs, 0, 0, 1, 1, 2'b00, 13'h0));
        d = (int'(n) + 1) * (T_RC + 2);
      end
      3'd4: begin exp_q.push_back(mk(k, cs, 0, 0, 0, 1, 2'b00, pay)); d = 2 + T_MRD; end
      3'd5: begin exp_q.push_back(mk(k, cs, 0, 0, 1, 0, 2'b00, 13'h0)); d = 2 + T_RAS; m_lp = 1'b1; end
      3'd6: begin exp_q.push_back(mk(k, cs, 1, 1, 1, 0, 2'b00, 13'h0)); m_lp = 1'b1; end
      default: d = 0;
    endcase
    cur_req = r;
    bus_addr = 2'd0;
    bus_wdata = {10'b0, pay, n, b1, b2, m};
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = 2'd3;
    #0;
    while (bus_rdata[5]) @(negedge clk);
    chk(r, cyc, k + d, "busy end cycle");
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd3;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8", {30'b0, sd_cs_n}, 32'h3, "reset chip selects");
    chk("R6", {31'b0, sd_cke}, 32'h0, "reset cke");
    chk("R8", bus_rdata, 32'h0, "reset status");

    // R1 reserved code
    send_cmd("R1", 3'd7, 1, 1, 4'd0, 13'h0);
    bus_addr = 2'd0; #1;
    chk("R1", bus_rdata, 32'h0, "command word after reserved");

    // R10 timing word, R13 readback
    wr(2'd1, 32'h0030_2451);
    bus_addr = 2'd1; #1;
    chk("R13", bus_rdata, 32'h0030_2451, "timing readback");

    // R6 clock enable, R2 per-bank select
    send_cmd("R6", 3'd1, 1, 0, 4'd0, 13'h0);
    chk("R6", {31'b0, sd_cke}, 32'h1, "cke after clock enable");
    send_cmd("R2", 3'd1, 0, 1, 4'd0, 13'h0);
    bus_addr = 2'd0; #1;
    chk("R13", bus_rdata, 32'h0000_0009, "command readback");

    // R3 precharge both banks
    send_cmd("R3", 3'd2, 1, 1, 4'd0, 13'h0);
    // R4 refresh bursts
    send_cmd("R4", 3'd3, 1, 0, 4'd7, 13'h0);
    send_cmd("R4", 3'd3, 1, 1, 4'd0, 13'h0);
    // R5 load mode: CAS 3, burst code 1
    send_cmd("R5", 3'd4, 1, 1, 4'd0, 13'h031);

    // R9 write while busy
    @(negedge clk);
    k = cyc + 1;
    cur_req = "R9";
    exp_q.push_back(mk(k, 2'b00, 0, 1, 0, 1, 2'b00, 13'h400));
    bus_addr = 2'd0; bus_wdata = 32'h0000_001A; bus_wr = 1'b1;
    @(negedge clk);
    bus_wdata = 32'h0000_007B;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd3;
    #0;
    while (bus_rdata[5]) @(negedge clk);
    chk("R9", cyc, k + 2 + T_RP, "busy end with dropped write");
    chk("R9", {31'b0, bus_rdata[0]}, 32'h1, "sticky error set");
    bus_addr = 2'd0; #1;
    chk("R9", bus_rdata, 32'h0000_001A, "command word kept");
    wr(2'd3, 32'h1);
    #1;
    chk("R9", {31'b0, bus_rdata[0]}, 32'h0, "sticky error cleared");

    // R7 low-power entry and exit
    send_cmd("R7", 3'd5, 1, 1, 4'd0, 13'h0);
    chk("R7", {31'b0, sd_cke}, 32'h0, "cke in self-refresh");
    send_cmd("R7", 3'd0, 1, 1, 4'd0, 13'h0);
    chk("R7", {31'b0, sd_cke}, 32'h1, "cke after wake");
    send_cmd("R7", 3'd6, 1, 0, 4'd0, 13'h0);
    chk("R7", {31'b0, sd_cke}, 32'h0, "cke in power-down");
    send_cmd("R7", 3'd0, 1, 0, 4'd0, 13'h0);
    send_cmd("R7", 3'd0, 1, 1, 4'd0, 13'h0);

    // R11 periodic refresh, interval 40
    @(negedge clk);
    k = cyc + 1;
    cur_req = "R11";
    for (int j = 1; j <= 3; j++)
      exp_q.push_back(mk(k + j * 41, 2'b00, 0, 0, 1, 1, 2'b00, 13'h0));
    bus_addr = 2'd2; bus_wdata = 32'd80; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; #1;
    chk("R13", bus_rdata, 32'd80, "refresh word readback");
    while (cyc < k + 130) @(negedge clk);
    wr(2'd2, 32'd0);
    repeat (100) @(negedge clk);
    chk("R11", exp_q.size(), 0, "periodic refreshes seen");

    // R12 expiry during host burst, interval 30
    @(negedge clk);
    k = cyc + 1;
    cur_req = "R12";
    for (int j = 0; j < 8; j++)
      exp_q.push_back(mk(k + 10 + j * (T_RC + 2), 2'b10, 0, 0, 1, 1, 2'b00, 13'h0));
    exp_q.push_back(mk(k + 43, 2'b00, 0, 0, 1, 1, 2'b00, 13'h0));
    bus_addr = 2'd2; bus_wdata = 32'd60; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    while (cyc < k + 9) @(negedge clk);
    bus_addr = 2'd0; bus_wdata = {23'b0, 4'd7, 1'b1, 1'b0, 3'd3}; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd3;
    while (cyc < k + 50) @(negedge clk);
    wr(2'd2, 32'd0);
    repeat (80) @(negedge clk);
    chk("R12", exp_q.size(), 0, "held refresh seen");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule